// File: doc/BRIEF.md
# Overhead Channel Serial Drop Port

The block receives transport overhead bytes one at a time from a parallel, frame-synchronous source and drops two low-rate channels as serial bit streams, each with its own gated clock. The management channel gathers nine bytes per frame (D4 to D12) and sends them back-to-back as a 72-bit burst. The orderwire channel sends one byte per frame (E2). A companion lane carries the F1 user byte on the same orderwire clock and byte-sync strobe.

Bytes are written through an indexed port into a capture buffer. A frame-start pulse moves the whole buffer into the shift registers and starts both serializers. Because the shift registers form a second buffer, bytes for the next frame can be written while the current frame is still being shifted out. When pins are scarce, a shared-pin mode keeps the management channel on the pin pair and forces the orderwire data line low.

Top module: `ovh_serial_drop`

## Requirements
- R1: The write index selects the destination byte: 0 to 8 are D4 to D12 and are sent in that order, 9 is E2 on `ow_data_o`, 10 is F1 on `uc_data_o`. Writes with index 11 to 15 change nothing.
- R2: Every byte is sent MSB first. Each management bit is held for DCC_BIT_CYC cycles, and the first bit is driven in the cycle after the clock edge that samples `frame_start_i`.
- R3: Each serial clock is low in the first half of every bit period (cycles 0 to BIT_CYC/2-1) and high in the second half. It stays low while its channel is idle.
- R4: After its 72 bits, the management channel goes idle, with data and clock both low.
- R5: The E2 and F1 lanes send 8 bits each in parallel. Each bit is held for OW_BIT_CYC cycles and both lanes are timed by `ow_clk_o`.
- R6: `ow_sync_o` is high for exactly the first bit period of each orderwire byte and is low at all other times.
- R7: Bytes written while a frame is being shifted do not alter that frame. They are sent in the next frame.
- R8: A byte position that is not rewritten before a frame start is sent again with its previous value.
- R9: While `shared_pin_i` is high, `ow_data_o` is held low. The management pins, `ow_clk_o`, `ow_sync_o` and `uc_data_o` are unaffected.
- R10: Reset forces all outputs low, stops shifting at once and clears the capture buffer to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| frame_start_i | input | 1 | One-cycle pulse that loads the buffer and starts shifting |
| wr_en_i | input | 1 | Byte write strobe |
| wr_idx_i | input | 4 | Byte index (see R1) |
| wr_byte_i | input | 8 | Byte value |
| shared_pin_i | input | 1 | Shared-pin mode, orderwire data muted |
| dcc_data_o | output | 1 | Management channel serial data |
| dcc_clk_o | output | 1 | Management channel gated clock |
| ow_data_o | output | 1 | Orderwire (E2) serial data |
| uc_data_o | output | 1 | F1 user byte serial data |
| ow_clk_o | output | 1 | Gated clock shared by the E2 and F1 lanes |
| ow_sync_o | output | 1 | Byte-sync strobe for the E2 and F1 lanes |

## Verification
The main function is exercised with four frames that use different byte patterns: all ones, alternating 0xAA/0x55, ascending distinct values, and sparse single-bit values. Each output is compared cycle by cycle against a model built from the index map. A bit-order, byte-order or lane swap shows up as a mismatch with the distinct patterns, while the all-ones frame isolates clock and burst-length errors from data errors. The next frame is always written while the current one is still shifting, which separates a true second buffer from a single one. Two frames run in shared-pin mode with non-zero E2 data, so a missing mute is visible. Directed tests then rewrite a single byte together with writes to unused indices, and apply reset in the middle of a frame.

// File: rtl/ovh_pkg.sv
package ovh_pkg;
  localparam int IDX_W     = 4;
  localparam int DCC_BYTES = 9;
  localparam int IDX_E2    = 9;
  localparam int IDX_F1    = 10;
  localparam int N_SLOTS   = 11;
  typedef logic [7:0] ovh_byte_t;
endpackage

// File: rtl/ovh_capture.sv
module ovh_capture
  import ovh_pkg::*;
(
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      wr_en_i,
  input  logic [IDX_W-1:0]          wr_idx_i,
  input  ovh_byte_t                 wr_byte_i,
  output logic [DCC_BYTES*8-1:0]    dcc_bytes_o,
  output ovh_byte_t                 e2_byte_o,
  output ovh_byte_t                 f1_byte_o
);
  ovh_byte_t cap_q [N_SLOTS];

  for (genvar g = 0; g < N_SLOTS; g++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                       cap_q[g] <= '0;
      else if (wr_en_i && wr_idx_i == IDX_W'(g))         cap_q[g] <= wr_byte_i;
    end
  end

  // first management byte sits at the MSB end so it leaves first
  for (genvar g = 0; g < DCC_BYTES; g++) begin : g_dcc
    assign dcc_bytes_o[(DCC_BYTES-1-g)*8 +: 8] = cap_q[g];
  end

  assign e2_byte_o = cap_q[IDX_E2];
  assign f1_byte_o = cap_q[IDX_F1];
endmodule

// File: rtl/ovh_serializer.sv
module ovh_serializer #(
  parameter int N_LANES = 1,
  parameter int N_BYTES = 1,
  parameter int BIT_CYC = 4,
  localparam int N_BITS = N_BYTES * 8,
  localparam int BW     = $clog2(N_BITS),
  localparam int CW     = (BIT_CYC > 1) ? $clog2(BIT_CYC) : 1
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           load_i,
  input  logic [N_LANES-1:0][N_BITS-1:0] data_i,
  output logic [N_LANES-1:0]             ser_o,
  output logic                           sclk_o,
  output logic                           sync_o
);
  logic          busy_q;
  logic [BW-1:0] bit_q;
  logic [CW-1:0] cyc_q;
  logic          bit_end, last_bit;

  assign bit_end  = cyc_q == CW'(BIT_CYC - 1);
  assign last_bit = bit_q == BW'(N_BITS - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      bit_q  <= '0;
      cyc_q  <= '0;
    end else if (load_i) begin
      busy_q <= 1'b1;
      bit_q  <= '0;
      cyc_q  <= '0;
    end else if (busy_q) begin
      if (bit_end) begin
        cyc_q <= '0;
        if (last_bit) busy_q <= 1'b0;
        else          bit_q  <= bit_q + 1'b1;
      end else begin
        cyc_q <= cyc_q + 1'b1;
      end
    end
  end

  for (genvar l = 0; l < N_LANES; l++) begin : g_lane
    logic [N_BITS-1:0] sh_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                   sh_q <= '0;
      else if (load_i)               sh_q <= data_i[l];
      else if (busy_q && bit_end)    sh_q <= {sh_q[N_BITS-2:0], 1'b0};
    end
    assign ser_o[l] = busy_q & sh_q[N_BITS-1];
  end

  assign sclk_o = busy_q & (cyc_q >= CW'(BIT_CYC / 2));
  assign sync_o = busy_q & (bit_q[2:0] == 3'd0);
endmodule

// File: rtl/ovh_serial_drop.sv
module ovh_serial_drop
  import ovh_pkg::*;
#(
  parameter int DCC_BIT_CYC = 4,
  parameter int OW_BIT_CYC  = 36
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        frame_start_i,
  input  logic        wr_en_i,
  input  logic [3:0]  wr_idx_i,
  input  logic [7:0]  wr_byte_i,
  input  logic        shared_pin_i,
  output logic        dcc_data_o,
  output logic        dcc_clk_o,
  output logic        ow_data_o,
  output logic        uc_data_o,
  output logic        ow_clk_o,
  output logic        ow_sync_o
);
  logic [DCC_BYTES*8-1:0] dcc_bytes;
  ovh_byte_t              e2_byte, f1_byte;
  logic [0:0]             dcc_ser;
  logic [1:0]             ow_ser;
  logic                   dcc_sync;

  ovh_capture i_capture (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_en_i     (wr_en_i),
    .wr_idx_i    (wr_idx_i),
    .wr_byte_i   (wr_byte_i),
    .dcc_bytes_o (dcc_bytes),
    .e2_byte_o   (e2_byte),
    .f1_byte_o   (f1_byte)
  );

  ovh_serializer #(.N_LANES(1), .N_BYTES(DCC_BYTES), .BIT_CYC(DCC_BIT_CYC)) i_dcc_ser (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (frame_start_i),
    .data_i (dcc_bytes),
    .ser_o  (dcc_ser),
    .sclk_o (dcc_clk_o),
    .sync_o (dcc_sync)
  );

  // lane 1 carries E2, lane 0 carries F1
  ovh_serializer #(.N_LANES(2), .N_BYTES(1), .BIT_CYC(OW_BIT_CYC)) i_ow_ser (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (frame_start_i),
    .data_i ({e2_byte, f1_byte}),
    .ser_o  (ow_ser),
    .sclk_o (ow_clk_o),
    .sync_o (ow_sync_o)
  );

  assign dcc_data_o = dcc_ser[0];
  assign uc_data_o  = ow_ser[0];
  // shared pin pair: management wins, orderwire data muted
  assign ow_data_o  = shared_pin_i ? 1'b0 : ow_ser[1];
endmodule

// File: rtl/ovh_serial_drop_chk.sv
module ovh_serial_drop_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic shared_pin_i,
  input logic dcc_data_o,
  input logic dcc_clk_o,
  input logic ow_data_o,
  input logic uc_data_o,
  input logic ow_clk_o,
  input logic ow_sync_o,
  input logic dcc_sync
);
  p_ow_muted_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shared_pin_i |-> !ow_data_o);

  p_dcc_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dcc_clk_o && $past(dcc_clk_o)) |-> $stable(dcc_data_o));

  p_uc_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ow_clk_o && $past(ow_clk_o)) |-> $stable(uc_data_o));

  p_sync_lead_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ow_sync_o) |-> !ow_clk_o);

  p_dcc_byte_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dcc_sync) |-> !dcc_clk_o);
endmodule

bind ovh_serial_drop ovh_serial_drop_chk i_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .shared_pin_i (shared_pin_i),
  .dcc_data_o   (dcc_data_o),
  .dcc_clk_o    (dcc_clk_o),
  .ow_data_o    (ow_data_o),
  .uc_data_o    (uc_data_o),
  .ow_clk_o     (ow_clk_o),
  .ow_sync_o    (ow_sync_o),
  .dcc_sync     (dcc_sync)
);

// File: tb/test_ovh_serial_drop.sv
module test_ovh_serial_drop;
  localparam int DB = 4;
  localparam int OB = 36;
  localparam int FRAME = 72 * DB;
  localparam int NV = 4;
  // bit 88 = shared mode, byte i at [8*i +: 8]
  localparam logic [88:0] VEC [NV] = '{
    {1'b1, 88'hFF_FF_FF_FF_FF_FF_FF_FF_FF_FF_FF},
    {1'b0, 88'h81_7E_12_34_56_78_9A_BC_DE_F0_0F},
    {1'b1, 88'hA5_5A_AA_55_AA_55_AA_55_AA_55_AA},
    {1'b0, 88'h01_80_00_FF_00_FF_01_02_04_08_10}
  };

  logic clk = 0, rst_ni = 0, frame_start_i = 0, wr_en_i = 0, shared_pin_i = 0;
  logic [3:0] wr_idx_i = '0;
  logic [7:0] wr_byte_i = '0;
  logic dcc_data_o, dcc_clk_o, ow_data_o, uc_data_o, ow_clk_o, ow_sync_o;
  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  ovh_serial_drop i_ovh_serial_drop (
    .clk_i(clk), .rst_ni(rst_ni), .frame_start_i(frame_start_i),
    .wr_en_i(wr_en_i), .wr_idx_i(wr_idx_i), .wr_byte_i(wr_byte_i),
    .shared_pin_i(shared_pin_i), .dcc_data_o(dcc_data_o), .dcc_clk_o(dcc_clk_o),
    .ow_data_o(ow_data_o), .uc_data_o(uc_data_o), .ow_clk_o(ow_clk_o),
    .ow_sync_o(ow_sync_o)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  function automatic logic [5:0] outs();
    return {dcc_data_o, dcc_clk_o, ow_data_o, uc_data_o, ow_clk_o, ow_sync_o};
  endfunction

  task automatic write_all(input logic [87:0] v);
    for (int i = 0; i < 11; i++) begin
      @(negedge clk);
      wr_en_i = 1; wr_idx_i = 4'(i); wr_byte_i = v[8*i +: 8];
    end
    @(negedge clk);
    wr_en_i = 0;
  endtask

  // expects to be entered just after a negedge; leaves at a negedge
  task automatic run_frame(input logic [88:0] e, input bit wr_next, input logic [87:0] nxt,
                           input string tag);
    int e_dd = 0, e_ck = 0, e_ow = 0, e_sy = 0, e_mu = 0;
    frame_start_i = 1; shared_pin_i = e[88];
    @(negedge clk);
    frame_start_i = 0;
    for (int c = 0; c < FRAME; c++) begin
      int n = c / DB, m = c / OB;
      logic xdd, xdc, xod, xuc, xoc, xsy;
      xdd = e[8*(n/8) + 7 - (n%8)];
      xdc = (c % DB) >= DB/2;
      xod = e[88] ? 1'b0 : e[8*9 + 7 - m];
      xuc = e[8*10 + 7 - m];
      xoc = (c % OB) >= OB/2;
      xsy = (m == 0);
      if (dcc_data_o !== xdd) e_dd++;
      if (dcc_clk_o !== xdc || ow_clk_o !== xoc) e_ck++;
      if (ow_data_o !== xod || uc_data_o !== xuc) e_ow++;
      if (ow_sync_o !== xsy) e_sy++;
      if (e[88] && ow_data_o !== 1'b0) e_mu++;
      if (wr_next && c >= 100 && c < 111) begin
        wr_en_i = 1; wr_idx_i = 4'(c - 100); wr_byte_i = nxt[8*(c-100) +: 8];
      end else begin
        wr_en_i = 0;
      end
      @(negedge clk);
    end
    check(e_dd == 0, {tag, " R1 R2 R7 dcc data mismatches"}, e_dd, 0);
    check(e_ck == 0, {tag, " R3 clock mismatches"}, e_ck, 0);
    check(e_ow == 0, {tag, " R1 R5 orderwire/F1 data mismatches"}, e_ow, 0);
    check(e_sy == 0, {tag, " R6 sync mismatches"}, e_sy, 0);
    if (e[88]) check(e_mu == 0, {tag, " R9 muted data high"}, e_mu, 0);
    check(outs() == 6'b0, {tag, " R4 idle after burst"}, int'(outs()), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    logic [88:0] e;
    repeat (3) @(negedge clk);
    check(outs() == 6'b0, "R10 outputs low in reset", int'(outs()), 0);
    rst_ni = 1;
    write_all(VEC[0][87:0]);
    for (int k = 0; k < NV; k++)
      run_frame(VEC[k], k < NV-1, (k < NV-1) ? VEC[(k+1) % NV][87:0] : 88'h0, $sformatf("vec%0d", k));

    // R8 + R1: only byte 0 refreshed; unused indices written
    @(negedge clk); wr_en_i = 1; wr_idx_i = 4'd0;  wr_byte_i = 8'hC3;
    @(negedge clk); wr_idx_i = 4'd12; wr_byte_i = 8'hFF;
    @(negedge clk); wr_idx_i = 4'd15; wr_byte_i = 8'h00;
    @(negedge clk); wr_idx_i = 4'd11; wr_byte_i = 8'h77;
    @(negedge clk); wr_en_i = 0;
    e = VEC[3]; e[7:0] = 8'hC3; e[88] = 1'b0;
    run_frame(e, 1'b0, 88'h0, "R8 partial");

    // R10: reset mid-frame
    frame_start_i = 1;
    @(negedge clk); frame_start_i = 0;
    repeat (50) @(negedge clk);
    rst_ni = 0;
    @(negedge clk);
    check(outs() == 6'b0, "R10 outputs low after mid-frame reset", int'(outs()), 0);
    rst_ni = 1;
    @(negedge clk);
    check(outs() == 6'b0, "R10 shifting stopped after reset", int'(outs()), 0);
    run_frame(89'h0, 1'b0, 88'h0, "R10 cleared");
    summary();
  end
endmodule